// File: doc/BRIEF.md
# Chainable 8-bit Peripheral Tile

This block is one tile of a linear array of small peripheral engines. A single 8-bit datapath, made of a working count register, a period register and a compare register, is turned by configuration into a down-counting timer, an event counter, a pulse-width modulator or a shift-register pseudorandom sequencer. A CPU reaches all state through eight byte-wide registers on a simple write-strobe bus with combinational read data. The tile has two inputs: a data pin and a step pin. It has two function-dependent outputs and one interrupt line.

Tiles placed side by side are joined through a carry and reload link. The lower tile passes its terminal-count strobe upward, and the uppermost tile sends the reload command back down. Two tiles then behave as one 16-bit timer, and four tiles as one 32-bit timer. Only the uppermost tile of a group reports the interrupt.

Top module: `cfg_tile8`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads 0, and `out0`, `out1` and `irq` are low.
- R2: Each address holds what was last written to it and returns it on `bus_rdata`. Address 0 is the count, 1 the period, 2 the compare, 3 the control/status, 4 the function select, 5 the chain setup, 6 the step source and 7 the output enables. Bit 7 of address 3 is the exception (see R9).
- R3: Function select value 0 is timer mode. On each step the count decrements. A step taken at count 0 loads the period instead. In that same cycle `out0` is high, and outside such a step it is low.
- R4: A step happens only when control bit 0 (enable) is 1 and the step source is active. The step source is `tick_in`, or a constant 1 when bit 0 of address 6 is set. Without a step the count holds.
- R5: Function select value 1 is counter mode. It behaves like R3, but it steps only when `data_in` is high.
- R6: In timer mode a rising edge on `data_in` copies the count into the compare register, whether or not the tile is enabled. A steady high level copies nothing more.
- R7: Function select value 2 is PWM mode. It counts as in R3, and `out1` is high exactly while the count is greater than the compare value.
- R8: Function select value 3 is sequencer mode. Each step shifts the count left by one bit. The new bit 0 is the XOR of the bits in (count AND period). `out1` shows count bit 7, the bit shifted out next.
- R9: In a tile whose address 5 bit 1 is 0 (uppermost tile), a terminal step sets control bit 7. `irq` follows that bit. The bit stays set until a write to address 3 with bit 7 high clears it. A write with bit 7 low leaves it set. Control bits 6 to 0 take the written value.
- R10: With address 5 bit 0 set, a tile steps only while `chain_tc_in` is high. With address 5 bit 1 set, a tile wraps from 0 to 255 and reloads only on `chain_rld_in`, and it never sets its interrupt. Two tiles linked this way count a 16-bit value down and reload both halves at zero.
- R11: Bit 0 of address 7 gates `out0` and bit 1 gates `out1`. A cleared bit holds that output low, and counting goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick_in | input | 1 | Step input |
| data_in | input | 1 | Data input (count gate, capture edge) |
| chain_tc_in | input | 1 | Terminal-count strobe from the lower neighbour |
| chain_rld_in | input | 1 | Reload command from the upper neighbour |
| chain_tc_out | output | 1 | Terminal-count strobe to the upper neighbour |
| chain_rld_out | output | 1 | Reload command to the lower neighbour |
| out0 | output | 1 | Terminal-count pulse output |
| out1 | output | 1 | PWM or sequencer output |
| irq | output | 1 | Interrupt request |

## Verification
The timer is run from a small period through to its reload, so that a terminal pulse shows in the cycle it belongs to and not one cycle early or late. The counter is given steps with `data_in` low and then high, which separates gated counting from free counting. The PWM sweep crosses the compare value in both directions, which catches an off-by-one in the comparison. A 12-step sequencer run against a model computed in the bench catches feedback and shift-direction errors. A two-tile chain is driven through a low-half wrap with no reload and then through the full 16-bit terminal count, which tells carry from reload and the upper tile's interrupt from the lower tile's.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    FN_TIMER = 2'd0,
    FN_COUNT = 2'd1,
    FN_PWM   = 2'd2,
    FN_LFSR  = 2'd3
  } fn_e;

  localparam logic [AW-1:0] A_CNT  = 3'd0;
  localparam logic [AW-1:0] A_PER  = 3'd1;
  localparam logic [AW-1:0] A_CMP  = 3'd2;
  localparam logic [AW-1:0] A_CSR  = 3'd3;
  localparam logic [AW-1:0] A_FN   = 3'd4;
  localparam logic [AW-1:0] A_LINK = 3'd5;
  localparam logic [AW-1:0] A_SRC  = 3'd6;
  localparam logic [AW-1:0] A_OE   = 3'd7;
endpackage

// File: rtl/tile_ctl.sv
module tile_ctl
  import tile_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          irq_set,
  output logic [W-1:0]  csr_q,
  output logic [W-1:0]  fn_q,
  output logic [W-1:0]  link_q,
  output logic [W-1:0]  src_q,
  output logic [W-1:0]  oe_q
);
  logic [W-1:0] csr_d, fn_d, link_d, src_d, oe_d;
  logic         clr_wr;

  assign clr_wr = wr && (addr == A_CSR) && wdata[W-1];

  always_comb begin
    csr_d  = csr_q;
    fn_d   = fn_q;
    link_d = link_q;
    src_d  = src_q;
    oe_d   = oe_q;
    if (wr) begin
      case (addr)
        A_CSR: begin
          csr_d[W-2:0] = wdata[W-2:0];
          if (wdata[W-1]) csr_d[W-1] = 1'b0;
        end
        A_FN:    fn_d   = wdata;
        A_LINK:  link_d = wdata;
        A_SRC:   src_d  = wdata;
        A_OE:    oe_d   = wdata;
        default: ;
      endcase
    end
    if (irq_set) csr_d[W-1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= '0;
      fn_q   <= '0;
      link_q <= '0;
      src_q  <= '0;
      oe_q   <= '0;
    end else begin
      csr_q  <= csr_d;
      fn_q   <= fn_d;
      link_q <= link_d;
      src_q  <= src_d;
      oe_q   <= oe_d;
    end
  end

  // R9: the flag survives any cycle without a clearing write
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[W-1] && !clr_wr) |=> csr_q[W-1]);

  // R9: a terminal event always lands in the flag
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> csr_q[W-1]);
endmodule

// File: rtl/tile_dp.sv
module tile_dp
  import tile_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  fn_e           fn,
  input  logic          en,
  input  logic          tick,
  input  logic          data_in,
  input  logic          lo_link,
  input  logic          hi_link,
  input  logic          tc_in,
  input  logic          rld_in,
  output logic [W-1:0]  cnt_q,
  output logic [W-1:0]  per_q,
  output logic [W-1:0]  cmp_q,
  output logic          tc_out,
  output logic          rld_out,
  output logic          irq_set,
  output logic          raw0,
  output logic          raw1
);
  logic [W-1:0] cnt_d, per_d, cmp_d;
  logic         din_q;
  logic         is_lfsr, gate, step, at_zero, wrap, top, reload, fb;
  logic         wr_cnt, wr_cmp, cap;

  assign is_lfsr = (fn == FN_LFSR);
  assign gate    = (fn == FN_COUNT) ? data_in : 1'b1;
  assign step    = en && tick && (is_lfsr || (gate && (!lo_link || tc_in)));
  assign at_zero = (cnt_q == '0);
  assign wrap    = step && !is_lfsr && at_zero;
  assign top     = !hi_link;
  assign reload  = top ? wrap : (rld_in && step);
  assign fb      = ^(cnt_q & per_q);
  assign wr_cnt  = wr && (addr == A_CNT);
  assign wr_cmp  = wr && (addr == A_CMP);
  assign cap     = (fn == FN_TIMER) && data_in && !din_q;

  assign tc_out  = wrap;
  assign rld_out = top ? wrap : rld_in;
  assign irq_set = top && wrap;
  assign raw0    = wrap;
  assign raw1    = is_lfsr ? cnt_q[W-1] : ((fn == FN_PWM) && (cnt_q > cmp_q));

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    cmp_d = cmp_q;
    if (wr_cnt)            cnt_d = wdata;
    else if (step) begin
      if (is_lfsr)         cnt_d = {cnt_q[W-2:0], fb};
      else if (reload)     cnt_d = per_q;
      else                 cnt_d = cnt_q - 1'b1;
    end
    if (wr && (addr == A_PER)) per_d = wdata;
    if (wr_cmp)            cmp_d = wdata;
    else if (cap)          cmp_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
      din_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
      din_q <= data_in;
    end
  end

  // R3: terminal step in the top tile brings back the period
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && top && !wr_cnt) |=> (cnt_q == $past(per_q)));

  // R4: no step source or no enable means the count holds
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && tick) && !wr_cnt) |=> $stable(cnt_q));

  // R10: a follower tile waits for the carry from below
  p_chain_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_link && !tc_in && !is_lfsr && !wr_cnt) |=> $stable(cnt_q));

  // R6: rising data edge in timer mode snapshots the count
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !wr_cmp) |=> (cmp_q == $past(cnt_q)));

  // R8: sequencer moves every bit one place up
  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lfsr && step && !wr_cnt) |=> (cnt_q[W-1:1] == $past(cnt_q[W-2:0])));
endmodule

// File: rtl/cfg_tile8.sv
module cfg_tile8
  import tile_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          tick_in,
  input  logic          data_in,
  input  logic          chain_tc_in,
  input  logic          chain_rld_in,
  output logic          chain_tc_out,
  output logic          chain_rld_out,
  output logic          out0,
  output logic          out1,
  output logic          irq
);
  localparam int SYNC = 2;

  logic [SYNC-1:0] rst_sync;
  logic            rst_i;
  logic [W-1:0]    csr_q, fn_q, link_q, src_q, oe_q;
  logic [W-1:0]    cnt_q, per_q, cmp_q;
  logic            irq_set, raw0, raw1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC-2:0], 1'b1};
  end
  assign rst_i = rst_sync[SYNC-1];

  tile_ctl #(.W(W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .irq_set (irq_set),
    .csr_q   (csr_q),
    .fn_q    (fn_q),
    .link_q  (link_q),
    .src_q   (src_q),
    .oe_q    (oe_q)
  );

  tile_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .fn      (fn_e'(fn_q[1:0])),
    .en      (csr_q[0]),
    .tick    (tick_in | src_q[0]),
    .data_in (data_in),
    .lo_link (link_q[0]),
    .hi_link (link_q[1]),
    .tc_in   (chain_tc_in),
    .rld_in  (chain_rld_in),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .cmp_q   (cmp_q),
    .tc_out  (chain_tc_out),
    .rld_out (chain_rld_out),
    .irq_set (irq_set),
    .raw0    (raw0),
    .raw1    (raw1)
  );

  always_comb begin
    case (bus_addr)
      A_CNT:   bus_rdata = cnt_q;
      A_PER:   bus_rdata = per_q;
      A_CMP:   bus_rdata = cmp_q;
      A_CSR:   bus_rdata = csr_q;
      A_FN:    bus_rdata = fn_q;
      A_LINK:  bus_rdata = link_q;
      A_SRC:   bus_rdata = src_q;
      default: bus_rdata = oe_q;
    endcase
  end

  assign out0 = raw0 & oe_q[0];
  assign out1 = raw1 & oe_q[1];
  assign irq  = csr_q[W-1];

  // R10: a tile with an upper neighbour never raises its own interrupt
  p_no_irq_below_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (link_q[1] && !irq) |=> (!irq || $past(bus_wr && bus_addr == A_LINK)));
endmodule

// File: tb/test_cfg_tile8.sv
module test_cfg_tile8;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_lo, wr_hi;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rd_lo, rd_hi;
  logic       tick, din;
  logic       lo_tc, lo_rld, hi_tc, hi_rld;
  logic       lo_o0, lo_o1, lo_irq, hi_o0, hi_o1, hi_irq;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cfg_tile8 i_cfg_tile8 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_lo), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_lo), .tick_in(tick), .data_in(din),
    .chain_tc_in(1'b0), .chain_rld_in(hi_rld),
    .chain_tc_out(lo_tc), .chain_rld_out(lo_rld),
    .out0(lo_o0), .out1(lo_o1), .irq(lo_irq));

  cfg_tile8 i_cfg_tile8_hi (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_hi), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_hi), .tick_in(tick), .data_in(din),
    .chain_tc_in(lo_tc), .chain_rld_in(1'b0),
    .chain_tc_out(hi_tc), .chain_rld_out(hi_rld),
    .out0(hi_o0), .out1(hi_o1), .irq(hi_irq));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit hi, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic rd(input bit hi, input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = hi ? rd_hi : rd_lo;
  endtask

  task automatic pulse(output logic o0, output logic o1, output logic h0);
    @(negedge clk);
    tick = 1'b1;
    #1;
    o0 = lo_o0; o1 = lo_o1; h0 = hi_o0;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(1'b0, 3'(a), v);
      chk("R1 reg reset", v, 0);
    end
    chk("R1 outputs reset", {lo_o0, lo_o1, lo_irq}, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(1'b0, 3'd1, 8'hA5);
    wr(1'b0, 3'd6, 8'h5A);
    wr(1'b0, 3'd2, 8'h3C);
    rd(1'b0, 3'd1, v); chk("R2 period readback", v, 8'hA5);
    rd(1'b0, 3'd6, v); chk("R2 source readback", v, 8'h5A);
    rd(1'b0, 3'd2, v); chk("R2 compare readback", v, 8'h3C);
    wr(1'b0, 3'd6, 8'h00);
  endtask

  task automatic t_timer;
    logic o0, o1, h0;
    logic [7:0] v;
    wr(1'b0, 3'd4, 8'd0);
    wr(1'b0, 3'd7, 8'h03);
    wr(1'b0, 3'd1, 8'd3);
    wr(1'b0, 3'd0, 8'd3);
    wr(1'b0, 3'd3, 8'h01);
    for (int i = 0; i < 3; i++) begin
      pulse(o0, o1, h0);
      chk("R3 no pulse before zero", o0, 0);
      rd(1'b0, 3'd0, v);
      chk("R3 count decrement", v, 2 - i);
    end
    pulse(o0, o1, h0);
    chk("R3 terminal pulse", o0, 1);
    rd(1'b0, 3'd0, v);
    chk("R3 reload from period", v, 3);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    rd(1'b0, 3'd3, v);
    chk("R9 flag set by terminal", v, 8'h81);
    chk("R9 irq port", lo_irq, 1);
    wr(1'b0, 3'd3, 8'h01);
    rd(1'b0, 3'd3, v);
    chk("R9 write zero keeps flag", v, 8'h81);
    wr(1'b0, 3'd3, 8'h81);
    rd(1'b0, 3'd3, v);
    chk("R9 write one clears flag", v, 8'h01);
    chk("R9 irq port cleared", lo_irq, 0);
  endtask

  task automatic t_gating;
    logic o0, o1, h0;
    logic [7:0] v;
    wr(1'b0, 3'd0, 8'd7);
    repeat (3) @(negedge clk);
    rd(1'b0, 3'd0, v);
    chk("R4 no tick no step", v, 7);
    wr(1'b0, 3'd3, 8'h00);
    pulse(o0, o1, h0);
    rd(1'b0, 3'd0, v);
    chk("R4 disabled no step", v, 7);
    wr(1'b0, 3'd6, 8'h01);
    wr(1'b0, 3'd3, 8'h01);
    rd(1'b0, 3'd0, v);
    chk("R4 enable edge itself no step", v, 7);
    @(negedge clk);
    rd(1'b0, 3'd0, v);
    chk("R4 free-run source steps", v, 6);
    wr(1'b0, 3'd3, 8'h00);
    wr(1'b0, 3'd6, 8'h00);
  endtask

  task automatic t_counter;
    logic o0, o1, h0;
    logic [7:0] v;
    wr(1'b0, 3'd4, 8'd1);
    wr(1'b0, 3'd1, 8'd9);
    wr(1'b0, 3'd0, 8'd5);
    wr(1'b0, 3'd2, 8'h11);
    wr(1'b0, 3'd3, 8'h01);
    din = 1'b0;
    pulse(o0, o1, h0);
    rd(1'b0, 3'd0, v);
    chk("R5 data low no count", v, 5);
    din = 1'b1;
    pulse(o0, o1, h0);
    rd(1'b0, 3'd0, v);
    chk("R5 data high counts", v, 4);
    pulse(o0, o1, h0);
    rd(1'b0, 3'd0, v);
    chk("R5 second count", v, 3);
    rd(1'b0, 3'd2, v);
    chk("R6 no capture outside timer", v, 8'h11);
    din = 1'b0;
    wr(1'b0, 3'd3, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] v;
    wr(1'b0, 3'd4, 8'd0);
    wr(1'b0, 3'd0, 8'h40);
    wr(1'b0, 3'd2, 8'h00);
    @(negedge clk);
    din = 1'b1;
    @(negedge clk);
    rd(1'b0, 3'd2, v);
    chk("R6 capture on rising data", v, 8'h40);
    wr(1'b0, 3'd0, 8'h41);
    @(negedge clk);
    rd(1'b0, 3'd2, v);
    chk("R6 level does not recapture", v, 8'h40);
    din = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_pwm;
    logic o0, o1, h0;
    logic exp1 [5] = '{1, 1, 0, 0, 1};
    wr(1'b0, 3'd4, 8'd2);
    wr(1'b0, 3'd7, 8'h03);
    wr(1'b0, 3'd1, 8'd3);
    wr(1'b0, 3'd0, 8'd3);
    wr(1'b0, 3'd2, 8'd1);
    wr(1'b0, 3'd3, 8'h01);
    for (int i = 0; i < 5; i++) begin
      pulse(o0, o1, h0);
      chk("R7 pwm level vs compare", o1, exp1[i]);
      chk("R7 pwm terminal pulse", o0, (i == 3) ? 1 : 0);
    end
  endtask

  task automatic t_oe;
    logic o0, o1, h0;
    logic [7:0] v;
    wr(1'b0, 3'd7, 8'h00);
    wr(1'b0, 3'd0, 8'd3);
    pulse(o0, o1, h0);
    chk("R11 out1 gated off", o1, 0);
    wr(1'b0, 3'd0, 8'd0);
    pulse(o0, o1, h0);
    chk("R11 out0 gated off", o0, 0);
    rd(1'b0, 3'd0, v);
    chk("R11 counting continues", v, 3);
    wr(1'b0, 3'd3, 8'h80);
  endtask

  task automatic t_lfsr;
    logic o0, o1, h0;
    logic [7:0] v, d;
    logic [7:0] m;
    m = 8'hB8;
    d = 8'h01;
    wr(1'b0, 3'd4, 8'd3);
    wr(1'b0, 3'd7, 8'h03);
    wr(1'b0, 3'd1, m);
    wr(1'b0, 3'd0, d);
    wr(1'b0, 3'd3, 8'h01);
    for (int i = 0; i < 12; i++) begin
      pulse(o0, o1, h0);
      chk("R8 shifted-out bit", o1, d[7]);
      d = {d[6:0], ^(d & m)};
      rd(1'b0, 3'd0, v);
      chk("R8 sequence value", v, d);
    end
    wr(1'b0, 3'd3, 8'h00);
  endtask

  task automatic t_chain;
    logic o0, o1, h0;
    logic [7:0] v;
    wr(1'b0, 3'd4, 8'd0);
    wr(1'b1, 3'd4, 8'd0);
    wr(1'b0, 3'd5, 8'h02);
    wr(1'b1, 3'd5, 8'h01);
    wr(1'b1, 3'd7, 8'h01);
    wr(1'b0, 3'd1, 8'd2);
    wr(1'b0, 3'd0, 8'd2);
    wr(1'b1, 3'd1, 8'd1);
    wr(1'b1, 3'd0, 8'd1);
    wr(1'b0, 3'd3, 8'h81);
    wr(1'b1, 3'd3, 8'h01);
    pulse(o0, o1, h0);
    pulse(o0, o1, h0);
    rd(1'b1, 3'd0, v);
    chk("R10 upper holds without carry", v, 1);
    pulse(o0, o1, h0);
    rd(1'b0, 3'd0, v);
    chk("R10 lower wraps on carry", v, 8'hFF);
    rd(1'b1, 3'd0, v);
    chk("R10 upper steps on carry", v, 0);
    chk("R10 no irq mid count", hi_irq, 0);
    repeat (255) pulse(o0, o1, h0);
    rd(1'b0, 3'd0, v);
    chk("R10 lower reaches zero", v, 0);
    pulse(o0, o1, h0);
    chk("R10 chain terminal pulse", h0, 1);
    rd(1'b0, 3'd0, v);
    chk("R10 lower reloaded", v, 2);
    rd(1'b1, 3'd0, v);
    chk("R10 upper reloaded", v, 1);
    chk("R10 upper raises irq", hi_irq, 1);
    rd(1'b0, 3'd3, v);
    chk("R10 lower keeps flag clear", v, 8'h01);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; addr = '0; wdata = '0;
    tick = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_timer();
    t_irq();
    t_gating();
    t_counter();
    t_capture();
    t_pwm();
    t_oe();
    t_lfsr();
    t_chain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule